// File: doc/BRIEF.md
# Banked memory mapping unit

This block widens a 16-bit logical CPU address to a 21-bit physical address. The logical space is split into eight 8KB windows, and each window has its own 8-bit bank register. The top three logical bits choose a bank register. The value of that register then takes the place of those three bits as the top eight physical bits. The low thirteen bits pass through unchanged. Translation is purely combinational from the current register contents, so the bus logic can use the physical address in the same cycle it presents the logical one.

The CPU core moves data between its accumulator and the bank registers through a transfer port. Each transfer carries an 8-bit one-hot-style selection mask in which bit k names bank register k.
- A store transfer (`xfer_dir` = 0) loads the accumulator byte into every selected register.
- A fetch transfer (`xfer_dir` = 1) returns one selected register to the core one cycle later.

A small controller sequences the fetch reply. It has two states:
- `XS_IDLE`: no reply is on the output.
- `XS_REPLY`: the captured byte is presented with `acc_rvalid` high.

The controller makes these transitions:
- IDLE→REPLY on a fetch request.
- REPLY→REPLY on a back-to-back fetch.
- REPLY→IDLE when no fetch is requested.
- IDLE→IDLE otherwise.

Top module: `bank_map_unit`

## Requirements
- R1: While reset is asserted and after it is released, every bank register holds $00, so `phys_addr` equals {8'h00, `log_addr`[12:0]}, and `acc_rvalid` is 0.
- R2: `phys_addr` is {bank[`log_addr`[15:13]], `log_addr`[12:0]}, formed combinationally from the current register contents.
- R3: Window k covers logical addresses k*$2000 through k*$2000+$1FFF: $1FFF uses bank 0, $2000 uses bank 1, and $FFFF uses bank 7.
- R4: On a clock edge with `xfer_valid`=1 and `xfer_dir`=0, every bank k whose `xfer_mask`[k] is 1 loads `acc_wdata`. Several banks may load in the same edge.
- R5: A store transfer with `xfer_mask`=$00 changes no bank register.
- R6: A store affects translation only from the cycle after its strobe edge. In the strobe cycle itself, translation still uses the old value.
- R7: A fetch transfer (`xfer_valid`=1, `xfer_dir`=1) puts the selected register on `acc_rdata` with `acc_rvalid`=1 in the next cycle. When several mask bits are set, the lowest set index wins. `acc_rvalid` is 0 in a cycle that follows no fetch.
- R8: A fetch with `xfer_mask`=$00 returns `acc_rdata`=$00 with `mask_invalid`=1. A fetch with a non-zero mask returns `mask_invalid`=0.
- R9: With bank 1 holding $F8, logical $3F13 translates to physical $1F1F13.
- R10: A fetch transfer leaves every bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | A transfer is requested this cycle |
| xfer_dir | input | 1 | 0 = store accumulator to banks, 1 = fetch bank to accumulator |
| xfer_mask | input | 8 | Bank selection, bit k selects bank k |
| acc_wdata | input | 8 | Accumulator byte for store transfers |
| acc_rdata | output | 8 | Fetched bank value |
| acc_rvalid | output | 1 | `acc_rdata` holds a fetch result |
| mask_invalid | output | 1 | The last fetch carried a zero mask |
| log_addr | input | 16 | Logical address |
| phys_addr | output | 21 | Translated physical address |

## Verification
The bench probes the window edges ($1FFF/$2000, $DFFF/$E000, $FFFF). A design that decoded the wrong bits would map these to a neighbouring bank. It checks the translation in the very cycle of a store. A design that bypassed the incoming byte into the translation path would show the new value one cycle early. Fetches with several mask bits set catch a priority encoder that favours the highest index. Zero-mask stores and fetches catch a design that loads every bank, or that reports stale data without raising the invalid flag. A long random run compares every cycle against a behavioural model, and it includes the $3F13 example.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    typedef enum logic [0:0] {
        XS_IDLE  = 1'b0,
        XS_REPLY = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/bank_reg_file.sv
module bank_reg_file #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [NUM_BANKS-1:0]             wr_mask,
    input  logic [BANK_W-1:0]                wr_data,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] banks
);
    // One register per window; each loads independently of the others.
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                banks[k] <= '0;
            end else if (wr_en && wr_mask[k]) begin
                banks[k] <= wr_data;
            end
        end

        a_r4_store_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_mask[k]) |=> (banks[k] == $past(wr_data)));
    end

    a_r5_zero_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_mask == '0)) |=> $stable(banks));
endmodule

// File: rtl/bank_read_sel.sv
module bank_read_sel #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8
) (
    input  logic [NUM_BANKS-1:0]             sel_mask,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
    output logic [BANK_W-1:0]                sel_data,
    output logic                             sel_none
);
    // Scan from the top down so the lowest set index is the last to assign.
    always_comb begin
        sel_data = '0;
        for (int k = NUM_BANKS - 1; k >= 0; k--) begin
            if (sel_mask[k]) begin
                sel_data = banks[k];
            end
        end
        sel_none = (sel_mask == '0);
    end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
    parameter int LOG_W     = 16,
    parameter int WIN_BITS  = 13,
    parameter int BANK_W    = 8,
    localparam int SEL_W     = LOG_W - WIN_BITS,
    localparam int NUM_BANKS = 1 << SEL_W,
    localparam int PHYS_W    = BANK_W + WIN_BITS
) (
    input  logic [LOG_W-1:0]                 log_addr,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
    output logic [PHYS_W-1:0]                phys_addr
);
    logic [SEL_W-1:0] win_idx;

    always_comb begin
        win_idx   = log_addr[LOG_W-1:WIN_BITS];
        phys_addr = {banks[win_idx], log_addr[WIN_BITS-1:0]};
    end
endmodule

// File: rtl/bank_map_unit.sv
module bank_map_unit #(
    parameter int LOG_W    = 16,
    parameter int WIN_BITS = 13,
    parameter int BANK_W   = 8,
    localparam int SEL_W     = LOG_W - WIN_BITS,
    localparam int NUM_BANKS = 1 << SEL_W,
    localparam int PHYS_W    = BANK_W + WIN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_valid,
    input  logic                 xfer_dir,
    input  logic [NUM_BANKS-1:0] xfer_mask,
    input  logic [BANK_W-1:0]    acc_wdata,
    output logic [BANK_W-1:0]    acc_rdata,
    output logic                 acc_rvalid,
    output logic                 mask_invalid,
    input  logic [LOG_W-1:0]     log_addr,
    output logic [PHYS_W-1:0]    phys_addr
);
    import bank_map_pkg::*;

    logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
    logic                             store_req;
    logic                             fetch_req;
    logic [BANK_W-1:0]                sel_data;
    logic                             sel_none;
    xfer_state_e                      state_q;
    xfer_state_e                      state_d;
    logic [BANK_W-1:0]                rdata_q;
    logic                             inval_q;

    assign store_req = xfer_valid && !xfer_dir;
    assign fetch_req = xfer_valid && xfer_dir;

    bank_reg_file #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_req),
        .wr_mask (xfer_mask),
        .wr_data (acc_wdata),
        .banks   (banks)
    );

    bank_read_sel #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_sel (
        .sel_mask (xfer_mask),
        .banks    (banks),
        .sel_data (sel_data),
        .sel_none (sel_none)
    );

    bank_xlate #(.LOG_W(LOG_W), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) u_xlate (
        .log_addr  (log_addr),
        .banks     (banks),
        .phys_addr (phys_addr)
    );

    // Next-state logic of the fetch reply controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  state_d = fetch_req ? XS_REPLY : XS_IDLE;
            XS_REPLY: state_d = fetch_req ? XS_REPLY : XS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: capture the fetched byte on the request edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            inval_q <= 1'b0;
        end else if (fetch_req) begin
            rdata_q <= sel_data;
            inval_q <= sel_none;
        end
    end

    assign acc_rvalid   = (state_q == XS_REPLY);
    assign acc_rdata    = rdata_q;
    assign mask_invalid = acc_rvalid && inval_q;

    a_r7_reply_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> acc_rvalid);

    a_r7_no_reply_without_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> !acc_rvalid);

    a_r8_zero_mask_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && (xfer_mask == '0)) |=> (mask_invalid && (acc_rdata == '0)));

    a_r10_fetch_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> $stable(banks));

    a_r2_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[WIN_BITS-1:0] == log_addr[WIN_BITS-1:0]);
endmodule

// File: tb/sim_bank_map_unit.sv
module sim_bank_map_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0;
    logic        xfer_dir = 1'b0;
    logic [7:0]  xfer_mask = 8'h00;
    logic [7:0]  acc_wdata = 8'h00;
    logic [7:0]  acc_rdata;
    logic        acc_rvalid;
    logic        mask_invalid;
    logic [15:0] log_addr = 16'h0000;
    logic [20:0] phys_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Behavioural model state
    logic [7:0] model [8];
    bit         exp_rv = 1'b0;
    logic [7:0] exp_rd = 8'h00;
    bit         exp_inv = 1'b0;

    always #4 clk = ~clk;

    bank_map_unit u0 (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_dir(xfer_dir),
        .xfer_mask(xfer_mask), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_rvalid(acc_rvalid), .mask_invalid(mask_invalid),
        .log_addr(log_addr), .phys_addr(phys_addr)
    );

    function automatic logic [20:0] model_phys(input logic [15:0] a);
        int win;
        win = int'(a) / 8192;
        return {model[win], a[12:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check, then advance the model for the edge.
    task automatic step(input bit v, input bit d, input logic [7:0] m,
                        input logic [7:0] w, input logic [15:0] a, input string req);
        @(negedge clk);
        xfer_valid = v; xfer_dir = d; xfer_mask = m; acc_wdata = w; log_addr = a;
        #1;
        check(phys_addr == model_phys(a), req, "phys_addr", 32'(phys_addr), 32'(model_phys(a)));
        check(acc_rvalid == exp_rv, "R7", "acc_rvalid", 32'(acc_rvalid), 32'(exp_rv));
        if (exp_rv) begin
            check(acc_rdata == exp_rd, "R7", "acc_rdata", 32'(acc_rdata), 32'(exp_rd));
            check(mask_invalid == exp_inv, "R8", "mask_invalid", 32'(mask_invalid), 32'(exp_inv));
        end
        exp_rv = v && d;
        if (v && d) begin
            exp_rd = 8'h00;
            exp_inv = (m == 8'h00);
            for (int k = 7; k >= 0; k--) if (m[k]) exp_rd = model[k];
        end
        if (v && !d) begin
            for (int k = 0; k < 8; k++) if (m[k]) model[k] = w;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = 8'h00;
        log_addr = 16'hE123;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(phys_addr == 21'h00_0123, "R1", "phys during reset", 32'(phys_addr), 32'h0123);
        check(acc_rvalid == 1'b0, "R1", "rvalid during reset", 32'(acc_rvalid), 0);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 8'h00, 16'hFFFF, "R1");
        // R9: bank 1 = F8, 3F13 -> 1F1F13
        step(1, 0, 8'h02, 8'hF8, 16'h3F13, "R6");
        step(0, 0, 8'h00, 8'h00, 16'h3F13, "R9");
        check(phys_addr == 21'h1F1F13, "R9", "example", 32'(phys_addr), 32'h1F1F13);
        // R4: multi-bank store, distinct values per window
        for (int k = 0; k < 8; k++) step(1, 0, 8'(1 << k), 8'(8'h10 + k), 16'h0000, "R4");
        step(1, 0, 8'h81, 8'hA5, 16'h0000, "R4");
        // R3: window boundaries
        step(0, 0, 8'h00, 8'h00, 16'h1FFF, "R3");
        step(0, 0, 8'h00, 8'h00, 16'h2000, "R3");
        step(0, 0, 8'h00, 8'h00, 16'hDFFF, "R3");
        step(0, 0, 8'h00, 8'h00, 16'hE000, "R3");
        step(0, 0, 8'h00, 8'h00, 16'hFFFF, "R3");
        // R5: zero-mask store, then observe all windows
        step(1, 0, 8'h00, 8'h77, 16'h4000, "R5");
        for (int k = 0; k < 8; k++) step(0, 0, 8'h00, 8'h00, 16'(k * 8192 + 5), "R5");
        // R6: translation in strobe cycle uses old value
        step(1, 0, 8'h10, 8'h3C, 16'h8001, "R6");
        step(0, 0, 8'h00, 8'h00, 16'h8001, "R6");
        // R7: fetches, lowest index wins, back-to-back
        step(1, 1, 8'hC0, 8'h00, 16'h0000, "R7");
        step(1, 1, 8'h0A, 8'h00, 16'h0000, "R7");
        step(1, 1, 8'h80, 8'h00, 16'h0000, "R7");
        // R8: zero-mask fetch
        step(1, 1, 8'h00, 8'h00, 16'h0000, "R8");
        // R10: after fetches, banks unchanged
        for (int k = 0; k < 8; k++) step(0, 0, 8'h00, 8'h00, 16'(k * 8192 + 16'h1ABC), "R10");
        // Random run against the model (R2)
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] m;
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: m = 8'h00;
                1: m = 8'(1 << ($urandom % 8));
                2: m = 8'($urandom);
                default: m = 8'hFF;
            endcase
            step(1'($urandom % 2), 1'($urandom % 2), m, 8'($urandom), 16'($urandom), "R2");
        end
        step(0, 0, 8'h00, 8'h00, 16'h0000, "R2");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule